// File: doc/BRIEF.md
# Debug Low-Power Status and Reset-Hold Register

This block is a pair of registers that a debugger reads and writes over a simple word-addressed bus. One register reports what state the core is in (halted, sleeping, deep-sleeping). It also holds two sticky flags that record that the system has come back from a low-power mode. One flag is for the retention mode, in which the debug logic kept its state. The other is for the deeper modes, in which the debug logic lost its state and has to be set up again. The debugger loses its link while the system is powered down. When the link returns, it reads these flags to learn what happened.

The second register is for control. A single self-clearing acknowledge bit clears both exit flags. Two level bits let the debugger hold the whole system in reset, or only the core. The system reset output also follows a software reset request from the core side. The debug logic itself is reset only by power-on reset or by a debug-reset request. The system reset it drives does not reset it.

Top module: `dbg_lpstat_reg`

## Requirements
- R1: After power-on reset the status word reads only the live core bits (both exit flags 0), the control word reads 0, and the core reset output is 0.
- R2: A one-cycle pulse on `ret_exit_pulse` sets status bit 9 at the next clock edge. The bit stays set through any number of later cycles without an acknowledge.
- R3: A one-cycle pulse on `loss_exit_pulse` sets status bit 10 at the next clock edge. The bit stays set until acknowledged.
- R4: Writing the control word (address 1) with bit 0 set clears both exit flags at that clock edge. Control bit 0 always reads back 0.
- R5: When an exit pulse and an acknowledge write fall in the same cycle, the pulsed flag is set after the edge.
- R6: Status bit 16 equals `core_halted`, bit 17 equals `core_deepsleep` and bit 18 equals `core_sleeping`, with no clock delay. Sleeping with no deep-sleep means a wait mode. Sleeping with deep-sleep means a stop mode.
- R7: Status bits 0 to 8, 11 to 15 and 19 to 31 always read 0.
- R8: Control bit 1 is a system-reset hold. While it is 1, `sys_reset_out` is 1. It reads back as written.
- R9: Control bit 2 is a core-reset hold. While it is 1, `core_reset_out` is 1, and `sys_reset_out` is not driven by it. It reads back as written.
- R10: `sys_reset_out` is 1 whenever `sw_sysreset_req` is 1, whatever the control bits are. The software request changes no flag or control bit.
- R11: `dbg_rst_req` high at a clock edge clears both exit flags and both hold bits at that edge.
- R12: Writes to the status address (address 0) change nothing. Reads of any address other than 0 and 1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug-domain clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| dbg_rst_req | input | 1 | Debugger request to reset the debug logic, sampled at the clock edge |
| bus_addr | input | ADDR_W (2) | Word address: 0 = status, 1 = control |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| ret_exit_pulse | input | 1 | Pulse: recovery from the retention low-power mode |
| loss_exit_pulse | input | 1 | Pulse: recovery from a state-loss low-power mode |
| core_halted | input | 1 | Core is in debug halt |
| core_sleeping | input | 1 | Core is sleeping |
| core_deepsleep | input | 1 | Core sleep is deep |
| sw_sysreset_req | input | 1 | Software system-reset request |
| sys_reset_out | output | 1 | System reset request |
| core_reset_out | output | 1 | Core-only reset request |

## Verification
The sticky flags are driven by a scripted run of steps. Each step changes the pulses, the acknowledge strobe and the core state together. The steps separate four cases: a flag that holds by itself, a flag that an acknowledge clears, a pulse that collides with an acknowledge, and two flags set by different modes. Each step also changes the core sleep and halt inputs, covering both the wait encoding and the stop encoding. This catches swapped or delayed mirror bits, and every bit of the status word is compared, reserved ones included. Directed tests then try each hold bit alone, the software request alone, a debug reset with flags and holds set, writes to the read-only status word, and reads of unmapped addresses.

// File: rtl/dbg_lpstat_pkg.sv
package dbg_lpstat_pkg;
   // status word bit positions, decoded by the debugger
   localparam int RET_EXIT_BIT  = 9;
   localparam int LOSS_EXIT_BIT = 10;
   localparam int HALT_BIT      = 16;
   localparam int DSLEEP_BIT    = 17;
   localparam int SLEEP_BIT     = 18;
   localparam int STAT_TOP_BIT  = 18;

   // control word bit positions
   localparam int ACK_BIT       = 0;
   localparam int SYS_HOLD_BIT  = 1;
   localparam int CORE_HOLD_BIT = 2;
   localparam int CTRL_BITS     = 3;

   // exit flag indices
   localparam int FLAG_RET  = 0;
   localparam int FLAG_LOSS = 1;
   localparam int NFLAGS    = 2;

   typedef struct packed {
      logic halted;
      logic sleeping;
      logic deepsleep;
   } core_state_t;
endpackage

// File: rtl/dbg_lpstat_sticky.sv
module dbg_lpstat_sticky #(
   parameter int NFLAG = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             dbg_clr,
   input  logic [NFLAG-1:0] set_pulse,
   input  logic             ack,
   output logic [NFLAG-1:0] flags
);
   // set wins over acknowledge so that no exit event is lost
   for (genvar g = 0; g < NFLAG; g++) begin : g_flag
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            flags[g] <= 1'b0;
         else if (dbg_clr)
            flags[g] <= 1'b0;
         else if (set_pulse[g])
            flags[g] <= 1'b1;
         else if (ack)
            flags[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/dbg_lpstat_ctrl.sv
module dbg_lpstat_ctrl (
   input  logic clk,
   input  logic por_n,
   input  logic dbg_clr,
   input  logic wr_en,
   input  logic wr_ack,
   input  logic wr_sys_hold,
   input  logic wr_core_hold,
   output logic ack_pulse,
   output logic sys_hold,
   output logic core_hold
);
   // the acknowledge is a strobe only: it has no storage
   assign ack_pulse = wr_en & wr_ack;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sys_hold  <= 1'b0;
         core_hold <= 1'b0;
      end else if (dbg_clr) begin
         sys_hold  <= 1'b0;
         core_hold <= 1'b0;
      end else if (wr_en) begin
         sys_hold  <= wr_sys_hold;
         core_hold <= wr_core_hold;
      end
   end
endmodule

// File: rtl/dbg_lpstat_rdmux.sv
module dbg_lpstat_rdmux
   import dbg_lpstat_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 2,
   parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [NFLAGS-1:0] flags,
   input  core_state_t       core_st,
   input  logic              sys_hold,
   input  logic              core_hold,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] ctrl_word;

   // bit-level assembly; unlisted bits are tied to 0
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == RET_EXIT_BIT) begin : g_ret
         assign stat_word[b] = flags[FLAG_RET];
      end else if (b == LOSS_EXIT_BIT) begin : g_loss
         assign stat_word[b] = flags[FLAG_LOSS];
      end else if (b == HALT_BIT) begin : g_halt
         assign stat_word[b] = core_st.halted;
      end else if (b == DSLEEP_BIT) begin : g_dsl
         assign stat_word[b] = core_st.deepsleep;
      end else if (b == SLEEP_BIT) begin : g_slp
         assign stat_word[b] = core_st.sleeping;
      end else begin : g_rsv
         assign stat_word[b] = 1'b0;
      end

      if (b == SYS_HOLD_BIT) begin : g_csys
         assign ctrl_word[b] = sys_hold;
      end else if (b == CORE_HOLD_BIT) begin : g_ccore
         assign ctrl_word[b] = core_hold;
      end else begin : g_crsv
         assign ctrl_word[b] = 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == STAT_ADDR)      rdata = stat_word;
      else if (addr == CTRL_ADDR) rdata = ctrl_word;
   end
endmodule

// File: rtl/dbg_lpstat_reg.sv
module dbg_lpstat_reg
   import dbg_lpstat_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter int                ADDR_W    = 2,
   parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              dbg_rst_req,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ret_exit_pulse,
   input  logic              loss_exit_pulse,
   input  logic              core_halted,
   input  logic              core_sleeping,
   input  logic              core_deepsleep,
   input  logic              sw_sysreset_req,
   output logic              sys_reset_out,
   output logic              core_reset_out
);
   if (DATA_W <= STAT_TOP_BIT) begin : g_chk_width
      $error("dbg_lpstat_reg: DATA_W must exceed the top status bit");
   end
   if (STAT_ADDR == CTRL_ADDR) begin : g_chk_addr
      $error("dbg_lpstat_reg: status and control addresses must differ");
   end

   logic              ctrl_wr;
   logic              ack_pulse;
   logic              sys_hold;
   logic              core_hold;
   logic [NFLAGS-1:0] exit_set;
   logic [NFLAGS-1:0] flags;
   core_state_t       core_st;
   logic              unused_wdata;

   assign ctrl_wr      = bus_wr & (bus_addr == CTRL_ADDR);
   assign unused_wdata = ^bus_wdata[DATA_W-1:CTRL_BITS];

   assign exit_set[FLAG_RET]  = ret_exit_pulse;
   assign exit_set[FLAG_LOSS] = loss_exit_pulse;

   assign core_st.halted    = core_halted;
   assign core_st.sleeping  = core_sleeping;
   assign core_st.deepsleep = core_deepsleep;

   dbg_lpstat_ctrl u_ctrl (
      .clk          (clk),
      .por_n        (por_n),
      .dbg_clr      (dbg_rst_req),
      .wr_en        (ctrl_wr),
      .wr_ack       (bus_wdata[ACK_BIT]),
      .wr_sys_hold  (bus_wdata[SYS_HOLD_BIT]),
      .wr_core_hold (bus_wdata[CORE_HOLD_BIT]),
      .ack_pulse    (ack_pulse),
      .sys_hold     (sys_hold),
      .core_hold    (core_hold)
   );

   dbg_lpstat_sticky #(.NFLAG(NFLAGS)) u_sticky (
      .clk       (clk),
      .por_n     (por_n),
      .dbg_clr   (dbg_rst_req),
      .set_pulse (exit_set),
      .ack       (ack_pulse),
      .flags     (flags)
   );

   dbg_lpstat_rdmux #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .STAT_ADDR (STAT_ADDR),
      .CTRL_ADDR (CTRL_ADDR)
   ) u_rdmux (
      .addr      (bus_addr),
      .flags     (flags),
      .core_st   (core_st),
      .sys_hold  (sys_hold),
      .core_hold (core_hold),
      .rdata     (bus_rdata)
   );

   assign sys_reset_out  = sys_hold | sw_sysreset_req;
   assign core_reset_out = core_hold;
endmodule

// File: rtl/dbg_lpstat_chk.sv
module dbg_lpstat_chk
   import dbg_lpstat_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter int                ADDR_W    = 2,
   parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 1
) (
   input logic              clk,
   input logic              por_n,
   input logic              dbg_rst_req,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              ret_exit_pulse,
   input logic              loss_exit_pulse,
   input logic [NFLAGS-1:0] flags,
   input logic              sys_reset_out,
   input logic              core_reset_out
);
   logic [DATA_W-1:0] rsvd_mask;
   logic              ack_wr;

   always_comb begin
      rsvd_mask = '1;
      rsvd_mask[RET_EXIT_BIT]  = 1'b0;
      rsvd_mask[LOSS_EXIT_BIT] = 1'b0;
      rsvd_mask[HALT_BIT]      = 1'b0;
      rsvd_mask[DSLEEP_BIT]    = 1'b0;
      rsvd_mask[SLEEP_BIT]     = 1'b0;
   end

   assign ack_wr = bus_wr && (bus_addr == CTRL_ADDR) && bus_wdata[ACK_BIT];

   assert_ret_sets_R2: assert property (@(posedge clk) disable iff (!por_n)
      (ret_exit_pulse && !dbg_rst_req) |=> flags[FLAG_RET]);

   assert_loss_sets_R3: assert property (@(posedge clk) disable iff (!por_n)
      (loss_exit_pulse && !dbg_rst_req) |=> flags[FLAG_LOSS]);

   assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!por_n)
      (ack_wr && !ret_exit_pulse && !loss_exit_pulse) |=> (flags == '0));

   assert_flag_holds_R2: assert property (@(posedge clk) disable iff (!por_n)
      (!ack_wr && !dbg_rst_req && !ret_exit_pulse && !loss_exit_pulse) |=> $stable(flags));

   assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!por_n)
      (bus_addr == STAT_ADDR) |-> ((bus_rdata & rsvd_mask) == '0));

   assert_sys_hold_R8: assert property (@(posedge clk) disable iff (!por_n)
      (bus_wr && bus_addr == CTRL_ADDR && bus_wdata[SYS_HOLD_BIT] && !dbg_rst_req)
      |=> sys_reset_out);

   assert_core_hold_R9: assert property (@(posedge clk) disable iff (!por_n)
      (bus_wr && bus_addr == CTRL_ADDR && bus_wdata[CORE_HOLD_BIT] && !dbg_rst_req)
      |=> core_reset_out);

   assert_dbg_clear_R11: assert property (@(posedge clk) disable iff (!por_n)
      dbg_rst_req |=> (flags == '0 && !core_reset_out));
endmodule

bind dbg_lpstat_reg dbg_lpstat_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .STAT_ADDR (STAT_ADDR),
   .CTRL_ADDR (CTRL_ADDR)
) u_chk (
   .clk             (clk),
   .por_n           (por_n),
   .dbg_rst_req     (dbg_rst_req),
   .bus_addr        (bus_addr),
   .bus_wr          (bus_wr),
   .bus_wdata       (bus_wdata),
   .bus_rdata       (bus_rdata),
   .ret_exit_pulse  (ret_exit_pulse),
   .loss_exit_pulse (loss_exit_pulse),
   .flags           (flags),
   .sys_reset_out   (sys_reset_out),
   .core_reset_out  (core_reset_out)
);

// File: tb/dbg_lpstat_reg_bench.sv
module dbg_lpstat_reg_bench;
   localparam int DW = 32;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          dbg_rst_req = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          ret_exit_pulse = 1'b0;
   logic          loss_exit_pulse = 1'b0;
   logic          core_halted = 1'b0;
   logic          core_sleeping = 1'b0;
   logic          core_deepsleep = 1'b0;
   logic          sw_sysreset_req = 1'b0;
   logic          sys_reset_out;
   logic          core_reset_out;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   dbg_lpstat_reg u_dbg_lpstat_reg (.*);

   // step: {ret, loss, ack, halt, sleep, deep, exp_loss_flag, exp_ret_flag}
   localparam logic [7:0] STEPS [10] = '{
      8'b000000_00,   // idle
      8'b100100_01,   // retention exit, core halted
      8'b000010_01,   // flag holds, wait mode
      8'b010011_11,   // state-loss exit, stop mode
      8'b001000_00,   // acknowledge clears both
      8'b101111_01,   // pulse with acknowledge: set wins
      8'b001000_00,
      8'b011000_10,   // loss pulse with acknowledge
      8'b000001_10,
      8'b001000_00
   };

   function automatic logic [DW-1:0] stat_exp(input logic r, input logic l,
         input logic h, input logic s, input logic d);
      logic [DW-1:0] w = '0;
      w[9] = r; w[10] = l; w[16] = h; w[17] = d; w[18] = s;
      return w;
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      logic [DW-1:0] d;
      repeat (3) @(negedge clk);
      por_n = 1'b1;

      // R1 reset state
      rd(2'd0, d); check("R1 status after reset", d, '0);
      rd(2'd1, d); check("R1 control after reset", d, '0);
      check("R1 reset outputs", {30'd0, sys_reset_out, core_reset_out}, '0);

      // R2 R3 R4 R5 R6 R7 table walk
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         {ret_exit_pulse, loss_exit_pulse} = STEPS[i][7:6];
         bus_wr = STEPS[i][5]; bus_addr = 2'd1; bus_wdata = STEPS[i][5] ? 32'h1 : 32'h0;
         {core_halted, core_sleeping, core_deepsleep} = STEPS[i][4:2];
         @(negedge clk);
         ret_exit_pulse = 1'b0; loss_exit_pulse = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
         bus_addr = 2'd0;
         #1 check("R2/R3/R4/R5/R6/R7 step", bus_rdata,
                  stat_exp(STEPS[i][0], STEPS[i][1], STEPS[i][4], STEPS[i][3], STEPS[i][2]));
      end
      core_halted = 1'b0; core_sleeping = 1'b0; core_deepsleep = 1'b0;

      // R8 system hold, R4 ack reads 0
      wr(2'd1, 32'h3);
      rd(2'd1, d); check("R8 sys hold readback, R4 ack reads 0", d, 32'h2);
      check("R8 sys_reset_out", {31'd0, sys_reset_out}, 32'd1);
      check("R9 core not held by sys hold", {31'd0, core_reset_out}, 32'd0);

      // R9 core hold alone
      wr(2'd1, 32'h4);
      rd(2'd1, d); check("R9 core hold readback", d, 32'h4);
      check("R9 outputs", {30'd0, sys_reset_out, core_reset_out}, 32'd1);

      // R10 software request, no state change
      ret_exit_pulse = 1'b1; @(negedge clk); ret_exit_pulse = 1'b0;
      sw_sysreset_req = 1'b1;
      repeat (2) @(negedge clk);
      #1 check("R10 sys_reset_out from sw request", {31'd0, sys_reset_out}, 32'd1);
      rd(2'd0, d); check("R10 flag kept under sw request", d, 32'h200);
      rd(2'd1, d); check("R10 control kept under sw request", d, 32'h4);
      sw_sysreset_req = 1'b0;

      // R12 write to status ignored, unmapped read zero
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, d); check("R12 status write ignored", d, 32'h200);
      rd(2'd1, d); check("R12 control untouched by status write", d, 32'h4);
      wr(2'd2, 32'h7);
      rd(2'd2, d); check("R12 unmapped read 2", d, '0);
      rd(2'd3, d); check("R12 unmapped read 3", d, '0);
      rd(2'd1, d); check("R12 unmapped write ignored", d, 32'h4);

      // R11 debug reset clears flags and holds
      wr(2'd1, 32'h6);
      loss_exit_pulse = 1'b1; @(negedge clk); loss_exit_pulse = 1'b0;
      dbg_rst_req = 1'b1; @(negedge clk); dbg_rst_req = 1'b0;
      rd(2'd0, d); check("R11 flags cleared", d, '0);
      rd(2'd1, d); check("R11 holds cleared", d, '0);
      check("R11 reset outputs", {30'd0, sys_reset_out, core_reset_out}, '0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule